// File: doc/BRIEF.md
# Snoop Push and Bus Request Controller

This controller decides what the L2 cache does when the system chipset snoops a transaction on the shared bus. Each snoop brings a 5-bit transfer type and the L2 tag lookup result (hit, dirty). A clean hit of an invalidating type, or any hit of a kill type, produces a one-cycle tag invalidate. A dirty hit of an invalidating or cleaning type starts a push. The controller retries the snooped transaction, requests the bus, issues a copyback, and then either invalidates the line or clears its dirty bit.

The retry window falls a fixed, parameterised number of cycles after the snoop address start. In the cycle right after the window the processor's bus request is sampled. If it is high, the L2 request drops in that same cycle and any grant is ignored. After a parameterised back-off the controller requests the bus again, and the push stays pending until the copyback finishes. Data movement is outside the block: a copyback-start pulse goes out, and a copyback-done pulse comes back.

Top module: `snoop_push_ctrl`

## Requirements
- R1: With snp_start_i high and tag_hit_i high, the types 00100, X0010 and X1110 (bit 4 on the left) on a clean line raise tag_inval_o for exactly one cycle, in the cycle after the start. artry_o and l2_br_o stay low.
- R2: The kill types 0110X and 00110 raise tag_inval_o in the cycle after the start on any hit, dirty or clean, with no retry and no bus request.
- R3: The following change no output and raise no retry: a miss of any type, a clean hit of type 00000 or X1010, and a hit of any type not listed in R1 or R2.
- R4: A dirty hit of an R1 type or of type 00000 / X1010 raises artry_o for exactly one cycle, RETRY_DLY cycles after the start cycle. l2_br_o is also high in that cycle.
- R5: In the cycle after the retry window, if sys_br_i is high, l2_br_o is low in that same cycle and l2_bg_i is ignored. No copyback starts while backing off.
- R6: After backing off, l2_br_o stays low for at least BACKOFF_CYC cycles. It rises again once sys_br_i is low. A grant then starts the copyback.
- R7: When l2_bg_i is high while l2_br_o is high outside the window, cb_start_o pulses for one cycle in the next cycle, and l2_br_o drops.
- R8: While cb_start_o is high, cb_tt_o is 00010, cb_burst_o is 1, cb_inhibit_o is 0 and cb_wrthru_o is 0. All four are zero otherwise.
- R9: One cycle after cb_done_i is sampled, a pushed line of an R1 type gets a one-cycle tag_inval_o. A pushed line of type 00000 / X1010 gets a one-cycle tag_clean_o instead.
- R10: snp_start_i is ignored while a push is pending. A kill snoop arriving then produces no tag_inval_o.
- R11: During and after reset, before any snoop, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| snp_start_i | input | 1 | Snoop address start, one cycle |
| snp_tt_i | input | 5 | Snooped transfer type |
| tag_hit_i | input | 1 | Tag lookup hit, valid with snp_start_i |
| tag_dirty_i | input | 1 | Hit line is dirty, valid with snp_start_i |
| sys_br_i | input | 1 | Processor bus request |
| l2_bg_i | input | 1 | Bus grant to the L2 |
| cb_done_i | input | 1 | Copyback data transfer finished |
| artry_o | output | 1 | Address retry |
| l2_br_o | output | 1 | L2 bus request |
| tag_inval_o | output | 1 | Invalidate the snooped line |
| tag_clean_o | output | 1 | Clear the dirty bit of the snooped line |
| cb_start_o | output | 1 | Copyback start pulse |
| cb_tt_o | output | 5 | Copyback transfer type |
| cb_burst_o | output | 1 | Copyback burst attribute |
| cb_inhibit_o | output | 1 | Copyback cache-inhibit attribute |
| cb_wrthru_o | output | 1 | Copyback write-through attribute |

## Verification
Tag updates for clean and kill hits come from a register, so they are due one cycle after the start edge. artry_o is due RETRY_DLY cycles after it. In the sample cycle, l2_br_o follows sys_br_i within the same cycle. cb_start_o arrives one cycle after the grant is sampled, and the tag update after a push one cycle after cb_done_i. The bench drives on falling edges and counts falling edges from the stimulus to the exact cycle due. The same-cycle request drop is checked one time step after sys_br_i changes. The neighbouring cycles are also checked, so each result is shown to be a single pulse.

// File: rtl/snoop_push_pkg.sv
package snoop_push_pkg;
  typedef enum logic [1:0] {SC_NONE, SC_INVAL, SC_CLEAN, SC_KILL} snp_class_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WIN, ST_ARB, ST_BACKOFF, ST_REQ, ST_GO, ST_WAITCB
  } push_st_e;
  localparam logic [4:0] CB_TT = 5'b00010;
endpackage

// File: rtl/snoop_class_dec.sv
module snoop_class_dec
  import snoop_push_pkg::*;
(
  input  logic [4:0]  tt_i,
  output snp_class_e  cls_o
);
  always_comb begin
    if (tt_i == 5'b00110 || tt_i[4:1] == 4'b0110)
      cls_o = SC_KILL;
    else if (tt_i == 5'b00100 || tt_i[3:0] == 4'b0010 || tt_i[3:0] == 4'b1110)
      cls_o = SC_INVAL;
    else if (tt_i == 5'b00000 || tt_i[3:0] == 4'b1010)
      cls_o = SC_CLEAN;
    else
      cls_o = SC_NONE;
  end
endmodule

// File: rtl/snoop_push_fsm.sv
module snoop_push_fsm
  import snoop_push_pkg::*;
#(
  parameter int unsigned RETRY_DLY   = 2,
  parameter int unsigned BACKOFF_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  snp_class_e cls_i,
  input  logic       hit_i,
  input  logic       dirty_i,
  input  logic       sys_br_i,
  input  logic       bg_i,
  input  logic       cb_done_i,
  output logic       artry_o,
  output logic       l2_br_o,
  output logic       cb_start_o,
  output logic       tag_inval_o,
  output logic       tag_clean_o
);
  localparam int unsigned WIN_W = $clog2(RETRY_DLY + 1);
  localparam int unsigned BO_W  = $clog2(BACKOFF_CYC + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(RETRY_DLY);
  localparam logic [BO_W-1:0]  BO_LAST  = BO_W'(BACKOFF_CYC - 1);

  push_st_e         state_q;
  logic [WIN_W-1:0] win_cnt_q;
  logic [BO_W-1:0]  bo_cnt_q;
  logic             push_inval_q;
  logic             inval_q, clean_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      win_cnt_q    <= '0;
      bo_cnt_q     <= '0;
      push_inval_q <= 1'b0;
      inval_q      <= 1'b0;
      clean_q      <= 1'b0;
    end else begin
      inval_q <= 1'b0;
      clean_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i && hit_i) begin
          if (cls_i == SC_KILL || (cls_i == SC_INVAL && !dirty_i)) begin
            inval_q <= 1'b1;
          end else if ((cls_i == SC_INVAL || cls_i == SC_CLEAN) && dirty_i) begin
            state_q      <= ST_WIN;
            win_cnt_q    <= WIN_W'(1);
            push_inval_q <= (cls_i == SC_INVAL);
          end
        end
        ST_WIN:
          if (win_cnt_q == WIN_LAST) state_q <= ST_ARB;
          else win_cnt_q <= win_cnt_q + 1'b1;
        // processor request sampled once, right after the window
        ST_ARB:
          if (sys_br_i) begin
            state_q  <= ST_BACKOFF;
            bo_cnt_q <= '0;
          end else if (bg_i) state_q <= ST_GO;
          else state_q <= ST_REQ;
        ST_BACKOFF:
          if (bo_cnt_q == BO_LAST) begin
            if (!sys_br_i) state_q <= ST_REQ;
          end else bo_cnt_q <= bo_cnt_q + 1'b1;
        ST_REQ:    if (bg_i) state_q <= ST_GO;
        ST_GO:     state_q <= ST_WAITCB;
        ST_WAITCB: if (cb_done_i) begin
          state_q <= ST_IDLE;
          inval_q <= push_inval_q;
          clean_q <= !push_inval_q;
        end
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    artry_o     = (state_q == ST_WIN) && (win_cnt_q == WIN_LAST);
    l2_br_o     = artry_o || (state_q == ST_REQ) ||
                  ((state_q == ST_ARB) && !sys_br_i);
    cb_start_o  = (state_q == ST_GO);
    tag_inval_o = inval_q;
    tag_clean_o = clean_q;
  end
endmodule

// File: rtl/snoop_cb_attr.sv
module snoop_cb_attr
  import snoop_push_pkg::*;
(
  input  logic       cb_start_i,
  output logic [4:0] tt_o,
  output logic       burst_o,
  output logic       inhibit_o,
  output logic       wrthru_o
);
  always_comb begin
    tt_o      = cb_start_i ? CB_TT : 5'b00000;
    burst_o   = cb_start_i;
    inhibit_o = 1'b0;
    wrthru_o  = 1'b0;
  end
endmodule

// File: rtl/snoop_push_ctrl.sv
module snoop_push_ctrl
  import snoop_push_pkg::*;
#(
  parameter int unsigned RETRY_DLY   = 2,
  parameter int unsigned BACKOFF_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       snp_start_i,
  input  logic [4:0] snp_tt_i,
  input  logic       tag_hit_i,
  input  logic       tag_dirty_i,
  input  logic       sys_br_i,
  input  logic       l2_bg_i,
  input  logic       cb_done_i,
  output logic       artry_o,
  output logic       l2_br_o,
  output logic       tag_inval_o,
  output logic       tag_clean_o,
  output logic       cb_start_o,
  output logic [4:0] cb_tt_o,
  output logic       cb_burst_o,
  output logic       cb_inhibit_o,
  output logic       cb_wrthru_o
);
  snp_class_e cls;

  snoop_class_dec u_dec (.tt_i(snp_tt_i), .cls_o(cls));

  snoop_push_fsm #(.RETRY_DLY(RETRY_DLY), .BACKOFF_CYC(BACKOFF_CYC)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (snp_start_i),
    .cls_i       (cls),
    .hit_i       (tag_hit_i),
    .dirty_i     (tag_dirty_i),
    .sys_br_i    (sys_br_i),
    .bg_i        (l2_bg_i),
    .cb_done_i   (cb_done_i),
    .artry_o     (artry_o),
    .l2_br_o     (l2_br_o),
    .cb_start_o  (cb_start_o),
    .tag_inval_o (tag_inval_o),
    .tag_clean_o (tag_clean_o)
  );

  snoop_cb_attr u_attr (
    .cb_start_i (cb_start_o),
    .tt_o       (cb_tt_o),
    .burst_o    (cb_burst_o),
    .inhibit_o  (cb_inhibit_o),
    .wrthru_o   (cb_wrthru_o)
  );
endmodule

// File: rtl/snoop_push_chk.sv
module snoop_push_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sys_br_i,
  input logic       artry_o,
  input logic       l2_br_o,
  input logic       tag_inval_o,
  input logic       tag_clean_o,
  input logic       cb_start_o,
  input logic [4:0] cb_tt_o,
  input logic       cb_burst_o,
  input logic       cb_inhibit_o,
  input logic       cb_wrthru_o
);
  // R4
  artry_with_br_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    artry_o |-> l2_br_o);
  // R4
  artry_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    artry_o |=> !artry_o);
  // R5
  backoff_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(artry_o) && sys_br_i) |-> !l2_br_o);
  // R7
  cb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cb_start_o |=> !cb_start_o);
  // R8
  cb_attr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cb_start_o |-> (cb_tt_o == 5'b00010 && cb_burst_o && !cb_inhibit_o && !cb_wrthru_o));
  // R9
  one_action_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tag_inval_o, tag_clean_o, cb_start_o, artry_o}));
endmodule

bind snoop_push_ctrl snoop_push_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sys_br_i     (sys_br_i),
  .artry_o      (artry_o),
  .l2_br_o      (l2_br_o),
  .tag_inval_o  (tag_inval_o),
  .tag_clean_o  (tag_clean_o),
  .cb_start_o   (cb_start_o),
  .cb_tt_o      (cb_tt_o),
  .cb_burst_o   (cb_burst_o),
  .cb_inhibit_o (cb_inhibit_o),
  .cb_wrthru_o  (cb_wrthru_o)
);

// File: tb/snoop_push_ctrl_bench.sv
module snoop_push_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic snp_start = 1'b0, tag_hit = 1'b0, tag_dirty = 1'b0;
  logic sys_br = 1'b0, l2_bg = 1'b0, cb_done = 1'b0;
  logic [4:0] snp_tt = '0;
  logic artry, l2_br, tag_inval, tag_clean, cb_start, cb_burst, cb_inhibit, cb_wrthru;
  logic [4:0] cb_tt;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  snoop_push_ctrl u_snoop_push_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .snp_start_i(snp_start), .snp_tt_i(snp_tt),
    .tag_hit_i(tag_hit), .tag_dirty_i(tag_dirty), .sys_br_i(sys_br),
    .l2_bg_i(l2_bg), .cb_done_i(cb_done), .artry_o(artry), .l2_br_o(l2_br),
    .tag_inval_o(tag_inval), .tag_clean_o(tag_clean), .cb_start_o(cb_start),
    .cb_tt_o(cb_tt), .cb_burst_o(cb_burst), .cb_inhibit_o(cb_inhibit),
    .cb_wrthru_o(cb_wrthru)
  );

  // {tt[4:0], hit, dirty, expected tag_inval}
  localparam logic [7:0] VEC [12] = '{
    {5'b00100, 1'b1, 1'b0, 1'b1}, {5'b10010, 1'b1, 1'b0, 1'b1},
    {5'b01110, 1'b1, 1'b0, 1'b1}, {5'b11110, 1'b1, 1'b0, 1'b1},
    {5'b00000, 1'b1, 1'b0, 1'b0}, {5'b01010, 1'b1, 1'b0, 1'b0},
    {5'b01100, 1'b1, 1'b1, 1'b1}, {5'b01101, 1'b1, 1'b0, 1'b1},
    {5'b00110, 1'b1, 1'b1, 1'b1}, {5'b00100, 1'b0, 1'b1, 1'b0},
    {5'b00000, 1'b0, 1'b0, 1'b0}, {5'b10111, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic snoop(input logic [4:0] tt, input logic hit, input logic dirty);
    @(negedge clk);
    snp_start = 1'b1; snp_tt = tt; tag_hit = hit; tag_dirty = dirty;
    @(negedge clk);
    snp_start = 1'b0; tag_hit = 1'b0; tag_dirty = 1'b0;
  endtask

  function automatic logic [15:0] outs();
    return {7'd0, artry, l2_br, tag_inval, tag_clean, cb_start, cb_tt};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset", outs(), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle", {outs()[15:5], cb_burst, cb_inhibit, cb_wrthru, 2'b0}, 16'h0);

    // R1 R2 R3 table walk
    for (int i = 0; i < 12; i++) begin
      snoop(VEC[i][7:3], VEC[i][2], VEC[i][1]);
      check($sformatf("R1/R2/R3 vec%0d cycle1", i), {artry, l2_br, tag_inval, tag_clean},
            {2'b00, VEC[i][0], 1'b0});
      @(negedge clk);
      check($sformatf("R1/R2/R3 vec%0d cycle2", i), {artry, l2_br, tag_inval, tag_clean}, 4'b0);
    end

    // R4 R7 R8 R10 R9: dirty invalidate-type push, no back-off
    snoop(5'b00100, 1'b1, 1'b1);
    check("R4 no early retry", {artry, l2_br}, 2'b00);
    @(negedge clk);
    check("R4 retry window", {artry, l2_br}, 2'b11);
    @(negedge clk);
    l2_bg = 1'b1; #1;
    check("R7 request held", {artry, l2_br, cb_start}, 3'b010);
    check("R8 attrs idle", {cb_tt, cb_burst, cb_inhibit, cb_wrthru}, 8'h0);
    @(negedge clk);
    l2_bg = 1'b0;
    check("R7 copyback start", {cb_start, l2_br}, 2'b10);
    check("R8 attrs", {cb_tt, cb_burst, cb_inhibit, cb_wrthru}, {5'b00010, 3'b100});
    snp_start = 1'b1; snp_tt = 5'b01100; tag_hit = 1'b1;
    @(negedge clk);
    snp_start = 1'b0; tag_hit = 1'b0;
    check("R7 single pulse", cb_start, 1'b0);
    check("R10 busy kill ignored", tag_inval, 1'b0);
    cb_done = 1'b1;
    @(negedge clk);
    cb_done = 1'b0;
    check("R9 invalidate after push", {tag_inval, tag_clean}, 2'b10);
    @(negedge clk);
    check("R9 single update", {tag_inval, tag_clean}, 2'b00);

    // R5 R6 R9: dirty clean-type push with back-off
    snoop(5'b01010, 1'b1, 1'b1);
    @(negedge clk);
    check("R4 retry window clean-type", artry, 1'b1);
    @(negedge clk);
    sys_br = 1'b1; l2_bg = 1'b1; #1;
    check("R5 request dropped", l2_br, 1'b0);
    @(negedge clk);
    sys_br = 1'b0;
    check("R5 grant ignored", {cb_start, l2_br}, 2'b00);
    @(negedge clk);
    check("R6 still backing off", {cb_start, l2_br}, 2'b00);
    @(negedge clk);
    check("R6 re-request", {cb_start, l2_br}, 2'b01);
    @(negedge clk);
    l2_bg = 1'b0;
    check("R6 copyback after re-grant", cb_start, 1'b1);
    @(negedge clk);
    cb_done = 1'b1;
    @(negedge clk);
    cb_done = 1'b0;
    check("R9 dirty cleared after push", {tag_inval, tag_clean}, 2'b01);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule